// File: doc/BRIEF.md
# Iterative Polar-to-Rectangular Rotator

This block converts a polar operand into rectangular coordinates. It takes a signed magnitude and a signed angle and returns X = R·cos θ and Y = R·sin θ. It works sequentially. Each coordinate has one shift-and-add datapath, and the block performs one micro-rotation per clock. A small table holds the elementary angle atan(2^-i) for each step. The sign of the residual angle chooses the turning direction at each step. When the folded angle has converged, a single constant multiply removes the growth of the rotations. The residual angle is also reported, as a measure of convergence.

A plain shift-and-add rotation converges only for angles up to about ±99°. A fold stage at the input therefore extends coverage to the full circle. When the input angle lies beyond ±90°, the stage moves the angle by ±180° toward zero and negates the starting vector. The sign of the angle decides which of the two corrections is applied.

Operands enter through a valid/ready handshake. The source may hold `in_valid` high with its operands for as long as it wishes. A transfer happens only on a clock edge where `in_ready` is also high. `in_ready` is low for the whole computation, so the block applies back-pressure for `ITER`+1 cycles after each accepted operand. The result side has no ready signal. `out_valid` is a single-cycle strobe, and the result stays on the output ports until the next result replaces it.

Top module: `cordic_rotator`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready` is 1, `out_valid` is 0, and `out_x`, `out_y` and `out_z` are 0.
- R2: `in_ready` is high exactly when the engine is idle. Operands are taken on a rising edge where `in_valid` and `in_ready` are both high. From the next cycle `in_ready` stays low until the cycle in which `out_valid` is asserted, when it is high again.
- R3: `out_valid` is high for exactly one cycle. That cycle follows the `ITER`+1-th rising edge after the accepting edge, which is 17 edges for the default of 16 iterations.
- R4: `in_valid` and operand changes while `in_ready` is low are ignored. They do not change the result in flight, and no second computation starts from them.
- R5: Angles are 16-bit two's complement, with code c meaning c·180/32767 degrees, so 32767 is +180° and 16384 is about +90°. For |c| ≤ 16384, `out_x` and `out_y` are within 24 LSB of R·cos θ and R·sin θ, with the gain already removed.
- R6: For |c| > 16384, up to and including -32768, the result meets the same 24 LSB tolerance. The input fold brings the angle back into the convergent range.
- R7: When `out_valid` is high, `out_z`, the residual angle in the same encoding, lies within ±8 codes.
- R8: A zero magnitude gives `out_x` = `out_y` = 0 exactly, for any angle.
- R9: A negative magnitude gives the same rotation of the negative vector, within 24 LSB.
- R10: `out_x`, `out_y` and `out_z` change only in a cycle in which `out_valid` is high. Between results they hold their values.
- R11: A result beyond the 16-bit range clamps to +32767 or -32768 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands on `in_mag` and `in_ang` are valid |
| in_ready | output | 1 | Engine idle; operands are accepted on this edge if `in_valid` is high |
| in_mag | input | W (16) | Signed magnitude R |
| in_ang | input | 16 | Signed angle θ, 32767 = +180° |
| out_valid | output | 1 | One-cycle strobe: result ports are updated |
| out_x | output | W (16) | Signed R·cos θ |
| out_y | output | W (16) | Signed R·sin θ |
| out_z | output | 16 | Signed residual angle after the last step |

## Verification
Some behaviours are checked by the bound assertions on every cycle: the handshake, the one-cycle result strobe, the fixed latency from acceptance, the residual angle staying small, and the outputs holding between strobes. Numerical accuracy can only be shown by the bench's scenarios, which compare against real-valued sine and cosine. These scenarios cover each quadrant, the ±90° fold threshold, both encodings of ±180°, negative and zero magnitudes, and clamping at full scale. The bench scenarios also check that operands offered while busy are really dropped.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Angle code width: 32767 encodes +180 degrees.
  localparam int ANG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROT,
    ST_SCALE
  } cordic_state_e;

  // atan(2^-i) in angle codes (radians * 32767 / pi), rounded.
  function automatic int atan_code(input int idx);
    case (idx)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_prefold.sv
module cordic_prefold #(
  parameter int W     = 16,
  parameter int XW    = 19,
  parameter int ZW    = 18,
  parameter int GUARD = 2
) (
  input  logic signed [W-1:0]                  mag_i,
  input  logic signed [cordic_pkg::ANG_W-1:0]  ang_i,
  output logic signed [XW-1:0]                 x0_o,
  output logic signed [ZW-1:0]                 z0_o
);
  localparam int AW = cordic_pkg::ANG_W;
  localparam logic signed [ZW-1:0] QUARTER = ZW'(2 ** (AW - 2));
  localparam logic signed [ZW-1:0] HALF_TURN = ZW'(2 ** (AW - 1) - 1);

  logic signed [XW-1:0] mag_ext;
  logic signed [ZW-1:0] ang_ext;
  logic                 outside;

  assign mag_ext = XW'(mag_i) <<< GUARD;
  assign ang_ext = ZW'(ang_i);
  assign outside = (ang_ext > QUARTER) || (ang_ext < -QUARTER);

  always_comb begin
    if (outside) begin
      x0_o = -mag_ext;
      z0_o = ang_ext[ZW-1] ? (ang_ext + HALF_TURN) : (ang_ext - HALF_TURN);
    end else begin
      x0_o = mag_ext;
      z0_o = ang_ext;
    end
  end
endmodule

// File: rtl/cordic_microstep.sv
module cordic_microstep #(
  parameter int XW = 19,
  parameter int ZW = 18,
  parameter int SW = 4
) (
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic        [SW-1:0] step_i,
  input  logic signed [ZW-1:0] ang_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [XW-1:0] x_sh, y_sh;

  assign x_sh = x_i >>> step_i;
  assign y_sh = y_i >>> step_i;

  always_comb begin
    if (z_i[ZW-1]) begin
      x_o = x_i + y_sh;
      y_o = y_i - x_sh;
      z_o = z_i + ang_i;
    end else begin
      x_o = x_i - y_sh;
      y_o = y_i + x_sh;
      z_o = z_i - ang_i;
    end
  end
endmodule

// File: rtl/cordic_gain.sv
module cordic_gain #(
  parameter int W         = 16,
  parameter int XW        = 19,
  parameter int GUARD     = 2,
  parameter int GAIN_FRAC = 16,
  parameter int GAIN_Q    = 39797
) (
  input  logic signed [XW-1:0] v_i,
  output logic signed [W-1:0]  v_o
);
  localparam int PW = XW + GAIN_FRAC + 2;
  localparam int SH = GAIN_FRAC + GUARD;
  localparam logic signed [PW-1:0] KQ   = PW'(GAIN_Q);
  localparam logic signed [PW-1:0] HI   = PW'(2 ** (W - 1) - 1);
  localparam logic signed [PW-1:0] LO   = -PW'(2 ** (W - 1));
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);

  logic signed [PW-1:0] prod, scaled;

  assign prod   = PW'(v_i) * KQ;
  assign scaled = (prod + HALF) >>> SH;

  always_comb begin
    if (scaled > HI)      v_o = HI[W-1:0];
    else if (scaled < LO) v_o = LO[W-1:0];
    else                  v_o = scaled[W-1:0];
  end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int W         = 16,
  parameter int ITER      = 16,
  parameter int GUARD     = 2,
  parameter int GAIN_FRAC = 16,
  parameter int GAIN_Q    = 39797
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic signed [W-1:0]                 in_mag,
  input  logic signed [cordic_pkg::ANG_W-1:0] in_ang,
  output logic                                out_valid,
  output logic signed [W-1:0]                 out_x,
  output logic signed [W-1:0]                 out_y,
  output logic signed [cordic_pkg::ANG_W-1:0] out_z
);
  import cordic_pkg::*;

  localparam int XW = W + GUARD + 1;
  localparam int ZW = ANG_W + 2;
  localparam int SW = $clog2(ITER);
  localparam logic [SW-1:0] LAST_STEP = SW'(ITER - 1);
  localparam logic signed [ZW-1:0] Z_HI = ZW'(2 ** (ANG_W - 1) - 1);
  localparam logic signed [ZW-1:0] Z_LO = -ZW'(2 ** (ANG_W - 1));

  cordic_state_e        state_q;
  logic signed [XW-1:0] x_q, y_q, x_nx, y_nx, x_init;
  logic signed [ZW-1:0] z_q, z_nx, z_init, ang_step;
  logic        [SW-1:0] step_q;
  logic signed [W-1:0]  x_fin, y_fin;

  assign in_ready = (state_q == ST_IDLE);
  assign ang_step = ZW'(atan_code(int'(step_q)));

  cordic_prefold #(.W(W), .XW(XW), .ZW(ZW), .GUARD(GUARD)) u_fold (
    .mag_i(in_mag), .ang_i(in_ang), .x0_o(x_init), .z0_o(z_init)
  );

  cordic_microstep #(.XW(XW), .ZW(ZW), .SW(SW)) u_step (
    .x_i(x_q), .y_i(y_q), .z_i(z_q), .step_i(step_q), .ang_i(ang_step),
    .x_o(x_nx), .y_o(y_nx), .z_o(z_nx)
  );

  cordic_gain #(.W(W), .XW(XW), .GUARD(GUARD), .GAIN_FRAC(GAIN_FRAC), .GAIN_Q(GAIN_Q)) u_gain_x (
    .v_i(x_q), .v_o(x_fin)
  );

  cordic_gain #(.W(W), .XW(XW), .GUARD(GUARD), .GAIN_FRAC(GAIN_FRAC), .GAIN_Q(GAIN_Q)) u_gain_y (
    .v_i(y_q), .v_o(y_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      x_q       <= '0;
      y_q       <= '0;
      z_q       <= '0;
      step_q    <= '0;
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_z     <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            x_q     <= x_init;
            y_q     <= '0;
            z_q     <= z_init;
            step_q  <= '0;
            state_q <= ST_ROT;
          end
        end
        ST_ROT: begin
          x_q <= x_nx;
          y_q <= y_nx;
          z_q <= z_nx;
          if (step_q == LAST_STEP) state_q <= ST_SCALE;
          else                     step_q  <= step_q + SW'(1);
        end
        ST_SCALE: begin
          out_x     <= x_fin;
          out_y     <= y_fin;
          if (z_q > Z_HI)      out_z <= Z_HI[ANG_W-1:0];
          else if (z_q < Z_LO) out_z <= Z_LO[ANG_W-1:0];
          else                 out_z <= z_q[ANG_W-1:0];
          out_valid <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
  parameter int W    = 16,
  parameter int ITER = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                in_valid,
  input logic                                in_ready,
  input logic                                out_valid,
  input logic signed [W-1:0]                 out_x,
  input logic signed [W-1:0]                 out_y,
  input logic signed [cordic_pkg::ANG_W-1:0] out_z
);
  localparam int AW = cordic_pkg::ANG_W;
  logic [7:0] since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_acc <= '0;
    else if (in_valid && in_ready) since_acc <= '0;
    else if (since_acc != 8'hFF)   since_acc <= since_acc + 8'd1;
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2
  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_acc == 8'(ITER + 1))); // R3
  AST_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_z <= AW'(8)) && (out_z >= -AW'(8)))); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_x) && $stable(out_y) && $stable(out_z))); // R10
endmodule

bind cordic_rotator cordic_rotator_chk #(.W(W), .ITER(ITER)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z)
);

// File: tb/cordic_rotator_tb.sv
`timescale 1ns/1ps
module cordic_rotator_tb;
  localparam int W = 16;
  localparam int ITER = 16;
  localparam int TOL = 24;
  localparam real PI = 3.14159265358979;
  localparam int NV = 12;
  localparam int VR[NV] = '{20000, 20000, 30000, 30000, 25000, 25000,
                            25000, 25000, 15000, 30000, 18000, 22000};
  localparam int VA[NV] = '{0, 5461, 16384, -16384, 16385, 32767,
                            -32767, -32768, 23665, -27000, -10923, 12000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] in_mag = '0;
  logic signed [15:0] in_ang = '0;
  logic out_valid;
  logic signed [W-1:0] out_x, out_y;
  logic signed [15:0] out_z;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cordic_rotator #(.W(W), .ITER(ITER)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mag(in_mag), .in_ang(in_ang), .out_valid(out_valid),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  task automatic check(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  function automatic int exp_coord(input int r, input int a, input bit use_sin);
    real th, v;
    th = real'(a) * PI / 32767.0;
    v = real'(r) * (use_sin ? $sin(th) : $cos(th));
    v = (v >= 0.0) ? v + 0.5 : v - 0.5;
    if (v > 32767.0) v = 32767.0;
    if (v < -32768.0) v = -32768.0;
    return $rtoi(v);
  endfunction

  // Offer operands, wait for the strobe, return latency in cycles.
  task automatic run_op(input int r, input int a, input int busy_poke, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_mag = W'(r); in_ang = 16'(a);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "in_ready after accept", int'(in_ready), 0, 0);
    lat = 0;
    for (int k = 0; k < 40; k++) begin
      if (k < busy_poke) begin
        in_valid = 1'b1; in_mag = -16'sd25000; in_ang = -16'sd20000;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
      lat++;
      if (out_valid) break;
    end
    in_valid = 1'b0;
    if (!out_valid) begin
      errors++; checks++;
      $display("FAIL R3 result strobe missing: actual 0 expected 1");
    end
  endtask

  task automatic check_result(input string req, input int r, input int a);
    check(req, "out_x", int'(out_x), exp_coord(r, a, 1'b0), TOL);
    check(req, "out_y", int'(out_y), exp_coord(r, a, 1'b1), TOL);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int hx, hy, hz;
    int extra;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "in_ready", int'(in_ready), 1, 0);
    check("R1", "out_valid", int'(out_valid), 0, 0);
    check("R1", "out_x", int'(out_x), 0, 0);
    check("R1", "out_y", int'(out_y), 0, 0);
    check("R1", "out_z", int'(out_z), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "in_ready after release", int'(in_ready), 1, 0);
    check("R1", "out_valid after release", int'(out_valid), 0, 0);

    // Vector table: accuracy, fold, latency, residual, hold
    for (int i = 0; i < NV; i++) begin
      run_op(VR[i], VA[i], 0, lat);
      check("R3", "latency", lat, ITER + 1, 0);
      check("R2", "in_ready with result", int'(in_ready), 1, 0);
      check_result((VA[i] > 16384 || VA[i] < -16384) ? "R6" : "R5", VR[i], VA[i]);
      check("R7", "out_z residual", int'(out_z), 0, 8);
      hx = int'(out_x); hy = int'(out_y); hz = int'(out_z);
      @(negedge clk);
      check("R3", "strobe width", int'(out_valid), 0, 0);
      check("R10", "out_x held", int'(out_x), hx, 0);
    end

    // R8 zero magnitude is exactly zero
    run_op(0, 10000, 0, lat);
    check("R8", "out_x", int'(out_x), 0, 0);
    check("R8", "out_y", int'(out_y), 0, 0);

    // R9 negative magnitude
    run_op(-12000, -8000, 0, lat);
    check_result("R9", -12000, -8000);
    run_op(-20000, 25000, 0, lat);
    check_result("R9", -20000, 25000);

    // R11 clamp at full scale instead of wrapping
    run_op(32767, 0, 0, lat);
    check("R11", "out_x clamp", int'(out_x), 32767, 2);
    check("R11", "out_y near zero", int'(out_y), 0, TOL);
    run_op(32767, 32767, 0, lat);
    check("R11", "out_x negative full scale", int'(out_x), -32767, 3);

    // R4 operands offered while busy are ignored and not queued
    run_op(20000, 5461, 4, lat);
    check("R4", "latency unaffected", lat, ITER + 1, 0);
    check_result("R4", 20000, 5461);
    hx = int'(out_x); hy = int'(out_y); hz = int'(out_z);
    extra = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    check("R4", "no queued strobe", extra, 0, 0);
    // R10 outputs held while idle
    check("R10", "out_x idle", int'(out_x), hx, 0);
    check("R10", "out_y idle", int'(out_y), hy, 0);
    check("R10", "out_z idle", int'(out_z), hz, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule